// File: doc/BRIEF.md
# Dual PS/2 Receiver with Flow Control

This block takes scan-code bytes from two PS/2 devices, a keyboard on channel 0 and a mouse on channel 1. Each device talks over an open-collector clock and data pair. Every line passes through a two-flop synchronizer and a glitch filter. A frame receiver then samples the data line on each falling edge of the filtered device clock. It checks the 11-bit frame and puts each good byte into a small FIFO kept for that device alone. Multi-byte scan codes therefore wait intact until the host gets to them.

The host never gets an interrupt. It polls through a synchronous strobe port. A select input picks the keyboard or mouse FIFO, and the port shows that FIFO's oldest byte with a valid flag. A one-cycle read strobe removes exactly that byte. The intended pattern is to read the keyboard on one poll and the mouse on the next, and the port supports any order.

Flow control works by holding a device's clock line low, which stops that device from sending:
- A device is held off while its FIFO is full.
- The mouse is held off while a keyboard frame is arriving, so the keyboard has priority.
- Both devices are held off while the host signals that a transfer of its own is in progress.

The block only ever pulls clock lines. It never drives either data line.

Top module: `ps2_dual_rx_hub`

## Requirements
- R1: A frame of eleven bits is accepted and its byte stored. The bits, in order of falling clock edges, are: bit 0 is the start bit and must be 0; bits 1 to 8 are the data byte with the least significant bit first; bit 9 is a parity bit that makes the total number of ones in the data and parity bits odd; bit 10 is the stop bit and must be 1.
- R2: A frame whose start bit is 1, whose parity is even, or whose stop bit is 0 is dropped, and nothing is stored.
- R3: Keyboard bytes (channel 0) and mouse bytes (channel 1) go to separate FIFOs. hostSel=0 selects the keyboard FIFO and hostSel=1 selects the mouse FIFO. Each FIFO returns its bytes in arrival order.
- R4: rdValid is 1 and rdData shows the oldest byte while the selected FIFO holds data. When the selected FIFO is empty, rdValid is 0 and rdData is 8'h00.
- R5: A one-cycle hostRd pulse removes exactly one byte from the selected FIFO. A pulse on an empty FIFO changes nothing.
- R6: While a device's FIFO holds FIFO_DEPTH bytes, that device's clock output enable is 1. The enable returns to 0 one cycle after a read frees space.
- R7: From the moment a keyboard start bit is sampled until that keyboard frame ends, msClkOe is 1.
- R8: While hostXfer is 1, both kbClkOe and msClkOe are 1 from the next cycle on. Both are released one cycle after hostXfer drops, unless R6 or R7 holds them.
- R9: If a frame is in progress and no falling clock edge arrives for TIMEOUT_CYCLES cycles, the partial frame is discarded, and the next frame is received correctly.
- R10: A clock-line pulse shorter than FILT_CYCLES cycles is ignored and does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| kbClkIn | input | 1 | Keyboard clock line as sensed |
| kbDataIn | input | 1 | Keyboard data line as sensed |
| msClkIn | input | 1 | Mouse clock line as sensed |
| msDataIn | input | 1 | Mouse data line as sensed |
| kbClkOe | output | 1 | 1 pulls the keyboard clock line low; 0 releases it |
| msClkOe | output | 1 | 1 pulls the mouse clock line low; 0 releases it |
| hostSel | input | 1 | FIFO select: 0 keyboard, 1 mouse |
| hostRd | input | 1 | Read strobe; removes one byte from the selected FIFO |
| hostXfer | input | 1 | Host transfer in progress; holds off both devices |
| rdData | output | 8 | Oldest byte of the selected FIFO, or 8'h00 when it is empty |
| rdValid | output | 1 | The selected FIFO holds at least one byte |

## Verification
The bench sends three kinds of flawed frame: one with a high start bit, one with even parity, and one with a low stop bit. Each must leave the FIFO empty. A receiver that skipped any one of these checks would hand the host a bogus byte.

The bench also checks how partial and noisy traffic is handled:
- A frame abandoned after four bits, followed by a good frame once the timeout has passed, must yield only the good byte. A design without the idle timeout would misalign every following frame.
- A two-cycle clock glitch must not start a frame. A design without the filter would count the glitch as a start bit.

For flow control, the bench fills the keyboard FIFO and checks that the keyboard clock is held and then released after one read. It probes the mouse clock in the middle of a keyboard frame and again afterwards. It raises hostXfer and checks both clocks. Finally, it reads an empty FIFO, then stores one byte and reads it, checking that a read on an empty FIFO removes nothing.

// File: rtl/ps2hub_pkg.sv
package ps2hub_pkg;
  localparam int NUM_CH = 2;
  localparam int KB_CH  = 0;
  localparam int MS_CH  = 1;
  localparam int FRAME_BITS = 11;

  // strobes from control to datapath, one bit per channel
  typedef struct packed {
    logic [NUM_CH-1:0] pop;
    logic [NUM_CH-1:0] inhibit;
  } hubCtl_t;
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      runCnt  <= '0;
      filtOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == filtOut) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_CYCLES - 1)) begin
        filtOut <= syncQ[1];
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx #(
  parameter int TIMEOUT_CYCLES = 200000,
  parameter int GUARD_CYCLES   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkF,
  input  logic       dataF,
  input  logic       inhibit,
  output logic [7:0] byteOut,
  output logic       byteStb,
  output logic       frameActive
);
  import ps2hub_pkg::*;
  localparam int IW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int GW = $clog2(GUARD_CYCLES + 1);

  logic          prevClk;
  logic [3:0]    bitCnt;
  logic [9:0]    shiftQ;
  logic [IW-1:0] idleCnt;
  logic [GW-1:0] guardCnt;
  logic          fallEdge, blocked, frameGood;
  logic [FRAME_BITS-1:0] nextFrame;

  assign fallEdge    = prevClk & ~clkF;
  assign blocked     = inhibit | (guardCnt != '0);
  assign nextFrame   = {dataF, shiftQ};
  assign frameActive = (bitCnt != 4'd0);
  assign frameGood   = !nextFrame[0] && nextFrame[10] && (^nextFrame[9:1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk  <= 1'b1;
      bitCnt   <= '0;
      shiftQ   <= '0;
      idleCnt  <= '0;
      guardCnt <= '0;
      byteOut  <= '0;
      byteStb  <= 1'b0;
    end else begin
      prevClk <= clkF;
      byteStb <= 1'b0;
      if (inhibit) guardCnt <= GW'(GUARD_CYCLES);
      else if (guardCnt != '0) guardCnt <= guardCnt - 1'b1;

      if (inhibit) begin
        bitCnt  <= '0;
        idleCnt <= '0;
      end else if (fallEdge && !blocked) begin
        idleCnt <= '0;
        shiftQ  <= nextFrame[10:1];
        if (bitCnt == 4'(FRAME_BITS - 1)) begin
          bitCnt  <= '0;
          byteStb <= frameGood;
          byteOut <= nextFrame[8:1];
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (bitCnt != 4'd0) begin
        if (idleCnt == IW'(TIMEOUT_CYCLES - 1)) begin
          bitCnt  <= '0;
          idleCnt <= '0;
        end else begin
          idleCnt <= idleCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_byte_fifo.sv
module ps2_byte_fifo #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       push,
  input  logic [7:0] din,
  input  logic       pop,
  output logic [7:0] head,
  output logic       empty,
  output logic       full
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]  mem [DEPTH];
  logic [AW:0] wrPtr, rdPtr;
  logic        doPush, doPop;

  assign empty  = (wrPtr == rdPtr);
  assign full   = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign head   = mem[rdPtr[AW-1:0]];
  assign doPush = push && !full;
  assign doPop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/ps2_hub_datapath.sv
module ps2_hub_datapath
  import ps2hub_pkg::*;
#(
  parameter int FIFO_DEPTH     = 4,
  parameter int FILT_CYCLES    = 4,
  parameter int TIMEOUT_CYCLES = 200000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] lineClk,
  input  logic [NUM_CH-1:0] lineData,
  input  hubCtl_t           ctl,
  input  logic              hostSel,
  output logic [NUM_CH-1:0] chFull,
  output logic [NUM_CH-1:0] chEmpty,
  output logic [NUM_CH-1:0] chActive,
  output logic [7:0]        rdData,
  output logic              rdValid
);
  localparam int GUARD_CYCLES = FILT_CYCLES + 4;

  logic [7:0] headByte [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic       clkF, dataF, stb;
    logic [7:0] rxByte;

    ps2_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_clkFilt (
      .clk(clk), .rstN(rstN), .rawIn(lineClk[c]), .filtOut(clkF));
    ps2_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_datFilt (
      .clk(clk), .rstN(rstN), .rawIn(lineData[c]), .filtOut(dataF));

    ps2_frame_rx #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .GUARD_CYCLES(GUARD_CYCLES)) u_rx (
      .clk(clk), .rstN(rstN), .clkF(clkF), .dataF(dataF),
      .inhibit(ctl.inhibit[c]), .byteOut(rxByte), .byteStb(stb),
      .frameActive(chActive[c]));

    ps2_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rstN(rstN), .push(stb), .din(rxByte), .pop(ctl.pop[c]),
      .head(headByte[c]), .empty(chEmpty[c]), .full(chFull[c]));
  end

  assign rdValid = !chEmpty[hostSel];
  assign rdData  = rdValid ? headByte[hostSel] : 8'h00;
endmodule

// File: rtl/ps2_hub_control.sv
module ps2_hub_control
  import ps2hub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostRd,
  input  logic              hostXfer,
  input  logic [NUM_CH-1:0] chFull,
  input  logic [NUM_CH-1:0] chEmpty,
  input  logic [NUM_CH-1:0] chActive,
  output hubCtl_t           ctl,
  output logic [NUM_CH-1:0] clkOe
);
  logic [NUM_CH-1:0] holdNext;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ctl.pop[c] = hostRd && (int'(hostSel) == c) && !chEmpty[c];
    end
    holdNext[KB_CH] = chFull[KB_CH] | hostXfer;
    holdNext[MS_CH] = chFull[MS_CH] | hostXfer | chActive[KB_CH];
    ctl.inhibit = clkOe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkOe <= '0;
    else       clkOe <= holdNext;
  end
endmodule

// File: rtl/ps2_dual_rx_hub.sv
module ps2_dual_rx_hub
  import ps2hub_pkg::*;
#(
  parameter int FIFO_DEPTH     = 4,
  parameter int FILT_CYCLES    = 4,
  parameter int TIMEOUT_CYCLES = 200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       kbClkIn,
  input  logic       kbDataIn,
  input  logic       msClkIn,
  input  logic       msDataIn,
  output logic       kbClkOe,
  output logic       msClkOe,
  input  logic       hostSel,
  input  logic       hostRd,
  input  logic       hostXfer,
  output logic [7:0] rdData,
  output logic       rdValid
);
  hubCtl_t           ctl;
  logic [NUM_CH-1:0] chFull, chEmpty, chActive, clkOe;

  ps2_hub_datapath #(
    .FIFO_DEPTH(FIFO_DEPTH), .FILT_CYCLES(FILT_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .lineClk({msClkIn, kbClkIn}), .lineData({msDataIn, kbDataIn}),
    .ctl(ctl), .hostSel(hostSel),
    .chFull(chFull), .chEmpty(chEmpty), .chActive(chActive),
    .rdData(rdData), .rdValid(rdValid));

  ps2_hub_control u_ctl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostRd(hostRd), .hostXfer(hostXfer),
    .chFull(chFull), .chEmpty(chEmpty), .chActive(chActive),
    .ctl(ctl), .clkOe(clkOe));

  assign kbClkOe = clkOe[KB_CH];
  assign msClkOe = clkOe[MS_CH];
endmodule

// File: rtl/ps2_dual_rx_hub_chk.sv
module ps2_dual_rx_hub_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostXfer,
  input logic       kbClkOe,
  input logic       msClkOe,
  input logic       rdValid,
  input logic [7:0] rdData,
  input logic [1:0] chFull,
  input logic [1:0] chActive
);
  // R4
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> rdData == 8'h00);

  // R8
  host_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostXfer |=> (kbClkOe && msClkOe));

  // R6
  kb_full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    chFull[0] |=> kbClkOe);

  // R6
  ms_full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    chFull[1] |=> msClkOe);

  // R7
  kb_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    chActive[0] |=> msClkOe);

  // R6
  kb_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chFull[0] && !hostXfer) |=> !kbClkOe);

  // R7
  ms_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chFull[1] && !hostXfer && !chActive[0]) |=> !msClkOe);
endmodule

bind ps2_dual_rx_hub ps2_dual_rx_hub_chk u_chk (
  .clk(clk), .rstN(rstN), .hostXfer(hostXfer), .kbClkOe(kbClkOe), .msClkOe(msClkOe),
  .rdValid(rdValid), .rdData(rdData), .chFull(chFull), .chActive(chActive));

// File: tb/tb_ps2_dual_rx_hub.sv
`timescale 1ns/1ps
module tb_ps2_dual_rx_hub;
  localparam int DEPTH = 4;
  localparam int FILT  = 4;
  localparam int TOUT  = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostRd = 1'b0, hostXfer = 1'b0;
  logic kbClkPull = 1'b0, kbDatPull = 1'b0, msClkPull = 1'b0, msDatPull = 1'b0;
  logic kbClkOe, msClkOe, rdValid;
  logic [7:0] rdData;
  logic kbClkLine, kbDatLine, msClkLine, msDatLine;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign kbClkLine = ~(kbClkPull | kbClkOe);
  assign msClkLine = ~(msClkPull | msClkOe);
  assign kbDatLine = ~kbDatPull;
  assign msDatLine = ~msDatPull;

  ps2_dual_rx_hub #(.FIFO_DEPTH(DEPTH), .FILT_CYCLES(FILT), .TIMEOUT_CYCLES(TOUT)) dut (
    .clk(clk), .rstN(rstN),
    .kbClkIn(kbClkLine), .kbDataIn(kbDatLine), .msClkIn(msClkLine), .msDataIn(msDatLine),
    .kbClkOe(kbClkOe), .msClkOe(msClkOe),
    .hostSel(hostSel), .hostRd(hostRd), .hostXfer(hostXfer),
    .rdData(rdData), .rdValid(rdValid));

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // flaw: 0 none, 1 even parity, 2 low stop, 3 high start; nBits < 11 abandons the frame
  task automatic sendFrame(input bit ch, input logic [7:0] b, input int flaw,
                           input int nBits, input bit probeMs);
    logic [10:0] fr;
    fr[0]   = (flaw == 3);
    fr[8:1] = b;
    fr[9]   = ~^b ^ (flaw == 1);
    fr[10]  = (flaw != 2);
    for (int i = 0; i < nBits; i++) begin
      if (ch) msDatPull = ~fr[i]; else kbDatPull = ~fr[i];
      waitCyc(10);
      if (ch) msClkPull = 1'b1; else kbClkPull = 1'b1;
      waitCyc(20);
      if (probeMs && i == 4) checkEq("R7 mouse held during keyboard frame", int'(msClkOe), 1);
      if (ch) msClkPull = 1'b0; else kbClkPull = 1'b0;
      waitCyc(10);
    end
    if (ch) msDatPull = 1'b0; else kbDatPull = 1'b0;
    waitCyc(30);
  endtask

  task automatic readByte(input bit sel, input int expValid, input int expData, input string tag);
    @(negedge clk);
    hostSel = sel;
    #1;
    checkEq({tag, " valid"}, int'(rdValid), expValid);
    checkEq({tag, " data"}, int'(rdData), expData);
    hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic testReset();
    hostSel = 1'b0;
    #1;
    checkEq("R4 reset kb empty valid", int'(rdValid), 0);
    checkEq("R4 reset kb empty data", int'(rdData), 0);
    checkEq("R8 reset kbClkOe released", int'(kbClkOe), 0);
    checkEq("R8 reset msClkOe released", int'(msClkOe), 0);
  endtask

  task automatic testGoodFrames();
    sendFrame(1'b0, 8'hE0, 0, 11, 1'b0);
    sendFrame(1'b0, 8'h70, 0, 11, 1'b0);
    sendFrame(1'b1, 8'h08, 0, 11, 1'b0);
    readByte(1'b0, 1, 8'hE0, "R1 kb first byte");
    readByte(1'b1, 1, 8'h08, "R3 mouse byte");
    readByte(1'b0, 1, 8'h70, "R3 kb second byte in order");
    readByte(1'b1, 0, 8'h00, "R4 mouse empty");
    readByte(1'b0, 0, 8'h00, "R4 kb empty");
  endtask

  task automatic testBadFrames();
    sendFrame(1'b0, 8'h5A, 1, 11, 1'b0);
    readByte(1'b0, 0, 8'h00, "R2 even parity dropped");
    sendFrame(1'b0, 8'h5A, 2, 11, 1'b0);
    readByte(1'b0, 0, 8'h00, "R2 low stop dropped");
    sendFrame(1'b1, 8'h5A, 3, 11, 1'b0);
    readByte(1'b1, 0, 8'h00, "R2 high start dropped");
  endtask

  task automatic testEmptyPop();
    readByte(1'b0, 0, 8'h00, "R5 pop on empty");
    sendFrame(1'b0, 8'hA5, 0, 11, 1'b0);
    readByte(1'b0, 1, 8'hA5, "R5 byte survives empty pop");
    readByte(1'b0, 0, 8'h00, "R5 one pop removes one byte");
  endtask

  task automatic testFull();
    for (int k = 0; k < DEPTH; k++) sendFrame(1'b0, 8'(8'h10 + k), 0, 11, 1'b0);
    waitCyc(5);
    checkEq("R6 kb held when FIFO full", int'(kbClkOe), 1);
    checkEq("R6 mouse not held by kb full", int'(msClkOe), 0);
    readByte(1'b0, 1, 8'h10, "R6 first of full FIFO");
    waitCyc(2);
    checkEq("R6 kb released after read", int'(kbClkOe), 0);
    for (int k = 1; k < DEPTH; k++) readByte(1'b0, 1, 8'h10 + k, "R6 drain order");
    readByte(1'b0, 0, 8'h00, "R6 drained");
  endtask

  task automatic testPriority();
    sendFrame(1'b0, 8'h1C, 0, 11, 1'b1);
    checkEq("R7 mouse released after keyboard frame", int'(msClkOe), 0);
    readByte(1'b0, 1, 8'h1C, "R7 keyboard byte");
  endtask

  task automatic testHostXfer();
    @(negedge clk);
    hostXfer = 1'b1;
    @(negedge clk);
    checkEq("R8 kb held during host transfer", int'(kbClkOe), 1);
    checkEq("R8 mouse held during host transfer", int'(msClkOe), 1);
    waitCyc(20);
    checkEq("R8 kb still held", int'(kbClkOe), 1);
    hostXfer = 1'b0;
    @(negedge clk);
    checkEq("R8 kb released after transfer", int'(kbClkOe), 0);
    checkEq("R8 mouse released after transfer", int'(msClkOe), 0);
    waitCyc(20);
    sendFrame(1'b1, 8'h33, 0, 11, 1'b0);
    readByte(1'b1, 1, 8'h33, "R8 mouse receives after transfer");
  endtask

  task automatic testTimeout();
    sendFrame(1'b0, 8'h99, 0, 4, 1'b0);
    waitCyc(TOUT + 200);
    sendFrame(1'b0, 8'h3C, 0, 11, 1'b0);
    readByte(1'b0, 1, 8'h3C, "R9 frame after abandoned partial");
    readByte(1'b0, 0, 8'h00, "R9 no extra byte");
  endtask

  task automatic testGlitch();
    @(negedge clk);
    kbClkPull = 1'b1;
    waitCyc(2);
    kbClkPull = 1'b0;
    waitCyc(20);
    sendFrame(1'b0, 8'h4B, 0, 11, 1'b0);
    readByte(1'b0, 1, 8'h4B, "R10 short glitch ignored");
    readByte(1'b0, 0, 8'h00, "R10 no extra byte");
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    testReset();
    testGoodFrames();
    testBadFrames();
    testEmptyPop();
    testFull();
    testPriority();
    testHostXfer();
    testTimeout();
    testGlitch();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule